// File: doc/BRIEF.md
# Multi-Level Reset Sequencer

This block drives the reset enables for three register groups in a network controller. The groups are the bus configuration registers, the device configuration registers and the remaining setup and state registers. An asynchronous hardware reset input clears all three groups. A command port accepts a two-bit opcode that selects one of four commands. A full soft reset clears every group except bus configuration. A partial reset clears only the general setup state. Self-test and dump each run inside a wrapped sequence.

A wrapped command first clears the setup state. It then starts an external test or dump engine through a start pulse and waits for that engine's done pulse. It finishes with a full soft reset. Two outputs follow the initialisation state. One tells software that the device must be initialised again. The other keeps frame transmit and receive disabled until a configure command is accepted. A busy output is high for the whole wrapped sequence, and port commands are dropped while it is high.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `hw_rst` is high, `clr_bus_cfg`, `clr_dev_cfg` and `clr_setup` are all high, and they go high without waiting for a clock edge. From the first clock edge on, `busy` and `eng_start` are 0, `reinit_req` is 1 and `txrx_en` is 0.
- R2: After `hw_rst` falls, the three clear outputs stay high through SYNC_STAGES-1 rising edges and fall after rising edge number SYNC_STAGES.
- R3: A command with op 2'b00 (full soft reset) accepted when idle raises `clr_dev_cfg` and `clr_setup` for exactly one cycle after the accepting edge, and leaves `clr_bus_cfg` low.
- R4: A command with op 2'b10 (partial reset) accepted when idle raises only `clr_setup` for exactly one cycle. It does not change `reinit_req` or `txrx_en`.
- R5: A command with op 2'b01 (self-test) or 2'b11 (dump) raises `clr_setup` alone for one cycle. In the next cycle `eng_start` is high for exactly one cycle. `eng_op` is 0 for self-test and 1 for dump.
- R6: The first `eng_done` seen after `eng_start` raises `clr_dev_cfg` and `clr_setup` for one cycle, and `busy` falls on the following edge. An `eng_done` seen while idle has no effect.
- R7: `busy` is high from the accepting edge of a wrapped command until the closing soft reset has completed. Port commands that arrive while `busy` is high are ignored.
- R8: `reinit_req` is set by a hardware reset, a full soft reset, a self-test or a dump. It is left as it was by a partial reset, and it is cleared by `cfg_cmd` while idle.
- R9: `txrx_en` is cleared by the same events that set `reinit_req`. It rises only on the edge after `cfg_cmd` is seen while not busy. A `cfg_cmd` seen while busy is ignored.
- R10: A hardware reset in the middle of a wrapped sequence abandons it. After release the block is idle with `busy` at 0 and `eng_start` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst | input | 1 | Hardware reset, active high, asynchronous assert |
| cmd_valid | input | 1 | Port command strobe |
| cmd_op | input | 2 | Port command opcode |
| cfg_cmd | input | 1 | Configure command executed |
| eng_done | input | 1 | Test/dump engine finished |
| clr_bus_cfg | output | 1 | Clear bus configuration registers |
| clr_dev_cfg | output | 1 | Clear device configuration registers |
| clr_setup | output | 1 | Clear other setup/state registers |
| eng_start | output | 1 | One-cycle start for test/dump engine |
| eng_op | output | 1 | Engine operation: 0 self-test, 1 dump |
| busy | output | 1 | Wrapped sequence in progress |
| reinit_req | output | 1 | Full initialisation required |
| txrx_en | output | 1 | Frame transmit/receive permitted |

## Verification
The bench builds the block with SYNC_STAGES set to 3 instead of the default 2. With three stages, the clear outputs must hold through two rising edges after release, which separates a correctly sized synchronizer from one that is a stage short or long. The opcode width is fixed by the package, so every opcode, including the wrapped dump and self-test paths, can be reached directly.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    localparam int OP_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_SOFT  = 2'b00,
        OP_TEST  = 2'b01,
        OP_PART  = 2'b10,
        OP_DUMP  = 2'b11
    } port_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE,
        ST_RUN,
        ST_POST
    } seq_state_e;

    typedef struct packed {
        logic dev;
        logic setup;
    } clr_req_t;

    localparam clr_req_t CLR_NONE  = '{dev: 1'b0, setup: 1'b0};
    localparam clr_req_t CLR_SETUP = '{dev: 1'b0, setup: 1'b1};
    localparam clr_req_t CLR_FULL  = '{dev: 1'b1, setup: 1'b1};

    // Wrapped commands (test, dump) have the low opcode bit set.
    function automatic logic op_is_wrapped(input port_op_e op);
        return op[0];
    endfunction

    // Dump is distinguished from self-test by the high opcode bit.
    function automatic logic op_is_dump(input port_op_e op);
        return op[1];
    endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    output logic srst
);
    localparam int N = (STAGES < 1) ? 1 : STAGES;

    logic [N-1:0] chain_q;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) chain_q <= '1;
        else      chain_q <= {chain_q[N-2+((N==1)?1:0):0] & {(N-1+((N==1)?1:0)){1'b1}}, 1'b0} & {N{(N > 1)}};
    end

    assign srst = chain_q[N-1];
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  port_op_e           cmd_op,
    input  logic               eng_done,
    output clr_req_t           clr,
    output logic               eng_start,
    output logic               eng_op,
    output logic               busy,
    output logic               full_rst
);
    seq_state_e state_q, state_d;
    clr_req_t   clr_q, clr_d;
    logic       start_q, start_d;
    logic       op_q, op_d;
    logic       accept;

    assign accept = cmd_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        clr_d   = CLR_NONE;
        start_d = 1'b0;
        op_d    = op_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (op_is_wrapped(cmd_op)) begin
                        clr_d   = CLR_SETUP;
                        op_d    = op_is_dump(cmd_op);
                        state_d = ST_PRE;
                    end else if (cmd_op == OP_PART) begin
                        clr_d = CLR_SETUP;
                    end else begin
                        clr_d = CLR_FULL;
                    end
                end
            end
            ST_PRE: begin
                start_d = 1'b1;
                state_d = ST_RUN;
            end
            ST_RUN: begin
                if (eng_done) begin
                    clr_d   = CLR_FULL;
                    state_d = ST_POST;
                end
            end
            ST_POST: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            clr_q   <= CLR_NONE;
            start_q <= 1'b0;
            op_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            clr_q   <= clr_d;
            start_q <= start_d;
            op_q    <= op_d;
        end
    end

    assign clr       = clr_q;
    assign eng_start = start_q;
    assign eng_op    = op_q;
    assign busy      = (state_q != ST_IDLE);
    assign full_rst  = accept && (cmd_op != OP_PART);
endmodule

// File: rtl/init_gate.sv
module init_gate (
    input  logic clk,
    input  logic rst,
    input  logic full_rst,
    input  logic cfg_cmd,
    input  logic busy,
    output logic reinit_req,
    output logic txrx_en
);
    logic cfg_ok;

    assign cfg_ok = cfg_cmd && !busy;

    always_ff @(posedge clk) begin
        if (rst || full_rst) begin
            reinit_req <= 1'b1;
            txrx_en    <= 1'b0;
        end else if (cfg_ok) begin
            reinit_req <= 1'b0;
            txrx_en    <= 1'b1;
        end
    end
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            hw_rst,
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_op,
    input  logic            cfg_cmd,
    input  logic            eng_done,
    output logic            clr_bus_cfg,
    output logic            clr_dev_cfg,
    output logic            clr_setup,
    output logic            eng_start,
    output logic            eng_op,
    output logic            busy,
    output logic            reinit_req,
    output logic            txrx_en
);
    logic     rst_i;
    clr_req_t clr;
    logic     full_rst;

    rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .arst (hw_rst),
        .srst (rst_i)
    );

    rst_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst_i),
        .cmd_valid (cmd_valid),
        .cmd_op    (port_op_e'(cmd_op)),
        .eng_done  (eng_done),
        .clr       (clr),
        .eng_start (eng_start),
        .eng_op    (eng_op),
        .busy      (busy),
        .full_rst  (full_rst)
    );

    init_gate u_gate (
        .clk        (clk),
        .rst        (rst_i),
        .full_rst   (full_rst),
        .cfg_cmd    (cfg_cmd),
        .busy       (busy),
        .reinit_req (reinit_req),
        .txrx_en    (txrx_en)
    );

    assign clr_bus_cfg = rst_i;
    assign clr_dev_cfg = rst_i | clr.dev;
    assign clr_setup   = rst_i | clr.setup;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
    input logic clk,
    input logic hw_rst,
    input logic rst_i,
    input logic cfg_cmd,
    input logic clr_bus_cfg,
    input logic clr_dev_cfg,
    input logic clr_setup,
    input logic eng_start,
    input logic busy,
    input logic txrx_en
);
    AST_HW_ALL_CLEAR: assert property (@(posedge clk)
        hw_rst |-> (clr_bus_cfg && clr_dev_cfg && clr_setup)); // R1

    AST_BUS_HW_ONLY: assert property (@(posedge clk) disable iff (rst_i)
        !clr_bus_cfg); // R3

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst_i)
        eng_start |=> !eng_start); // R5

    AST_START_AFTER_PRE: assert property (@(posedge clk) disable iff (rst_i)
        eng_start |-> ($past(clr_setup) && !clr_dev_cfg)); // R5

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst_i)
        eng_start |-> busy); // R7

    AST_POST_ENDS: assert property (@(posedge clk) disable iff (rst_i)
        (busy && clr_dev_cfg) |=> !busy); // R6

    AST_TXRX_OFF_BUSY: assert property (@(posedge clk) disable iff (rst_i)
        busy |-> !txrx_en); // R9

    AST_TXRX_NEEDS_CFG: assert property (@(posedge clk) disable iff (rst_i)
        $rose(txrx_en) |-> $past(cfg_cmd)); // R9
endmodule

bind rst_seq_ctrl rst_seq_chk u_chk (
    .clk         (clk),
    .hw_rst      (hw_rst),
    .rst_i       (rst_i),
    .cfg_cmd     (cfg_cmd),
    .clr_bus_cfg (clr_bus_cfg),
    .clr_dev_cfg (clr_dev_cfg),
    .clr_setup   (clr_setup),
    .eng_start   (eng_start),
    .busy        (busy),
    .txrx_en     (txrx_en)
);

// File: tb/tb_rst_seq_ctrl.sv
module tb_rst_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NSYNC      = 3;

    logic       clk = 1'b0;
    logic       hw_rst;
    logic       cmd_valid;
    logic [1:0] cmd_op;
    logic       cfg_cmd;
    logic       eng_done;
    logic       clr_bus_cfg, clr_dev_cfg, clr_setup;
    logic       eng_start, eng_op, busy, reinit_req, txrx_en;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        string      tag;
        logic [7:0] v;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_seq_ctrl #(.SYNC_STAGES(NSYNC)) dut (
        .clk         (clk),
        .hw_rst      (hw_rst),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cfg_cmd     (cfg_cmd),
        .eng_done    (eng_done),
        .clr_bus_cfg (clr_bus_cfg),
        .clr_dev_cfg (clr_dev_cfg),
        .clr_setup   (clr_setup),
        .eng_start   (eng_start),
        .eng_op      (eng_op),
        .busy        (busy),
        .reinit_req  (reinit_req),
        .txrx_en     (txrx_en)
    );

    // Observed vector: {bus, dev, setup, start, op, busy, reinit, txrx}
    function automatic logic [7:0] obs();
        return {clr_bus_cfg, clr_dev_cfg, clr_setup, eng_start,
                eng_op, busy, reinit_req, txrx_en};
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // Driver: drive one cycle of inputs, push expected outputs after the edge.
    task automatic cyc(input logic v, input logic [1:0] op, input logic cfg,
                       input logic done, input logic [7:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        cmd_valid = v;
        cmd_op    = op;
        cfg_cmd   = cfg;
        eng_done  = done;
        e.tag = tag;
        e.v   = exp;
        exp_q.push_back(e);
    endtask

    // Monitor: compare after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, obs(), e.v);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        hw_rst    = 1'b1;
        cmd_valid = 1'b0;
        cmd_op    = 2'b00;
        cfg_cmd   = 1'b0;
        eng_done  = 1'b0;

        repeat (2) @(negedge clk);
        chk("R1 reset state", obs(), 8'b1110_0010);

        // R2: release timing through the synchronizer
        hw_rst = 1'b0;
        for (int k = 1; k < NSYNC; k++) begin
            @(negedge clk);
            chk("R2 clears held", {clr_bus_cfg, clr_dev_cfg, clr_setup}, 3'b111);
        end
        @(negedge clk);
        chk("R2 clears released", {clr_bus_cfg, clr_dev_cfg, clr_setup}, 3'b000);

        // Scoreboard phase
        cyc(0, 2'b00, 1, 0, 8'b0000_0001, "R8 R9 cfg enables");
        cyc(0, 2'b00, 0, 0, 8'b0000_0001, "R9 enabled hold");
        cyc(1, 2'b10, 0, 0, 8'b0010_0001, "R4 partial reset");
        cyc(0, 2'b00, 0, 0, 8'b0000_0001, "R4 one cycle");
        cyc(1, 2'b00, 0, 0, 8'b0110_0010, "R3 soft reset");
        cyc(0, 2'b00, 0, 0, 8'b0000_0010, "R3 one cycle");
        cyc(0, 2'b00, 1, 0, 8'b0000_0001, "R8 cfg after soft");
        cyc(1, 2'b01, 0, 0, 8'b0010_0110, "R5 self-test pre clear");
        cyc(0, 2'b00, 0, 0, 8'b0001_0110, "R5 start test");
        cyc(1, 2'b00, 1, 0, 8'b0000_0110, "R7 R9 cmd and cfg ignored");
        cyc(0, 2'b00, 0, 1, 8'b0110_0110, "R6 post soft reset");
        cyc(0, 2'b00, 0, 0, 8'b0000_0010, "R6 busy falls");
        cyc(0, 2'b00, 1, 0, 8'b0000_0001, "R9 cfg after test");
        cyc(1, 2'b11, 0, 0, 8'b0010_1110, "R5 dump pre clear");
        cyc(0, 2'b00, 0, 0, 8'b0001_1110, "R5 start dump");
        cyc(0, 2'b00, 0, 0, 8'b0000_1110, "R7 waiting");
        cyc(0, 2'b00, 0, 1, 8'b0110_1110, "R6 dump post");
        cyc(0, 2'b00, 0, 0, 8'b0000_1010, "R6 dump idle");
        cyc(0, 2'b00, 0, 1, 8'b0000_1010, "R6 idle done ignored");
        cyc(0, 2'b00, 0, 0, 8'b0000_1010, "R6 idle hold");
        cyc(1, 2'b01, 0, 0, 8'b0010_0110, "R10 start test");
        cyc(0, 2'b00, 0, 0, 8'b0001_0110, "R10 engine started");
        while (exp_q.size() > 0) @(posedge clk);

        // R10: abort mid-sequence with hardware reset
        @(negedge clk);
        hw_rst = 1'b1;
        #1;
        chk("R1 R10 async clears", {clr_bus_cfg, clr_dev_cfg, clr_setup}, 3'b111);
        @(negedge clk);
        chk("R10 reset during run", obs(), 8'b1110_0010);
        hw_rst = 1'b0;
        repeat (NSYNC + 1) @(negedge clk);
        chk("R10 idle after abort", obs(), 8'b0000_0010);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule